// File: doc/BRIEF.md
# Boot Address Redirection Decoder

This block decodes processor addresses into chip selects for a board that can start from one of three places: on-board flash, an optional boot ROM, or memory out on the backplane bus. After reset the processor always fetches its first words from address zero, which in normal operation belongs to local RAM. While the block is in its boot state, any access to the low region is steered to the start device picked by a pair of static jumper inputs, and RAM is kept off those addresses.

Boot state ends by itself. The first memory access that reaches the chosen start device at its own normal address window is marked. At the end of that access, when the address strobe is released, the block returns every device to its normal window. No timer or register write is involved. Only a new synchronous reset enters boot state again. Backplane cycles get an address-modifier code built from the function code, and a flag that marks transfers wider than the 16-bit backplane data path.

Top module: `boot_redirect_decoder`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) the block is in boot state, and a fetch at address 0x000000 selects the start device.
- R2: The start device follows `boot_jmp`: 2'b00 and 2'b11 pick flash, 2'b01 picks the boot ROM, and 2'b10 picks backplane memory.
- R3: In boot state, a memory access below 2**BOOT_LG (default 0x100000) selects the start device and never RAM. RAM addresses above that region still select RAM.
- R4: Boot state ends at the end of the first access that hits the start device's normal window (flash 0x800000, ROM 0xA00000, backplane 0xC00000). The end of an access is the clock after `cpu_as_n` returns high. After that, address 0 selects RAM.
- R5: In boot state, accesses to the normal window of a device that is not the start device select that device and do not end boot state.
- R6: At most one chip select is high. None is high while `cpu_as_n` is high, for an unmapped address, or for a function code other than 1, 2, 5 or 6.
- R7: On a backplane cycle `vme_am` is 0x3E for a supervisor program access (fc 6), 0x3D for supervisor data (fc 5), 0x3A for user program (fc 2) and 0x39 for user data (fc 1). It is 0 when no backplane cycle is selected.
- R8: On a backplane cycle `vme_addr` carries the low VME_LG bits of `cpu_addr`, so a redirected fetch at 0 and the window base 0xC00000 both reach backplane address 0.
- R9: `vme_split` is high on a backplane cycle whose `cpu_size` is long (2'b00) or three-byte (2'b11), and low otherwise.
- R10: Boot state, once left, stays off until the next reset, and a later reset restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_fc | input | 3 | Processor function code |
| cpu_size | input | 2 | Transfer size (00 long, 01 byte, 10 word, 11 three-byte) |
| boot_jmp | input | 2 | Static start-device jumpers |
| cs_ram | output | 1 | Local RAM select |
| cs_flash | output | 1 | Flash select |
| cs_rom | output | 1 | Boot ROM select |
| cs_vme | output | 1 | Backplane cycle request |
| vme_addr | output | ADDR_W | Backplane address |
| vme_am | output | 6 | Backplane address-modifier code |
| vme_split | output | 1 | Backplane transfer wider than 16 bits |

## Verification
The bench builds the block with its default map: a 24-bit address, a 4 MB RAM window at 0, 2 MB of flash at 0x800000, 1 MB of ROM at 0xA00000, 4 MB of backplane space at 0xC00000, and a 1 MB boot region. Because the boot region is smaller than the RAM window, the bench can show that RAM above the low region stays reachable during boot, while the low region itself is redirected. Each jumper setting is run from reset. For each one the bench checks the redirected fetches, a visit to another device's window that must not end boot state, the exit access, and the RAM mapping that follows.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

    localparam int NUM_DEV = 4;

    // device index doubles as chip-select bit position
    typedef enum logic [1:0] {
        DEV_RAM   = 2'd0,
        DEV_FLASH = 2'd1,
        DEV_ROM   = 2'd2,
        DEV_VME   = 2'd3
    } dev_e;

    // backplane address-modifier codes for 24-bit space
    localparam logic [5:0] AM_SUP_PROG  = 6'h3E;
    localparam logic [5:0] AM_SUP_DATA  = 6'h3D;
    localparam logic [5:0] AM_USER_PROG = 6'h3A;
    localparam logic [5:0] AM_USER_DATA = 6'h39;

    typedef struct packed {
        logic boot;      // boot state active
        logic as_prev;   // strobe level seen last clock
        logic hit;       // current access reached start device's own window
    } boot_st_t;

    localparam boot_st_t BOOT_ST_RESET = '{boot: 1'b1, as_prev: 1'b1, hit: 1'b0};

endpackage

// File: rtl/bdec_window.sv
module bdec_window #(
    parameter int               AW   = 24,
    parameter int               LG   = 20,
    parameter logic [AW-1:0]    BASE = '0
) (
    input  logic [AW-LG-1:0] addr_hi,
    output logic             hit
);
    localparam logic [AW-LG-1:0] BASE_HI = BASE[AW-1:LG];

    always_comb begin
        hit = (addr_hi == BASE_HI);
    end
endmodule

// File: rtl/bdec_jumper.sv
module bdec_jumper
    import boot_dec_pkg::*;
(
    input  logic [1:0] jmp,
    output dev_e       start_dev
);
    always_comb begin
        unique case (jmp)
            2'b01:   start_dev = DEV_ROM;
            2'b10:   start_dev = DEV_VME;
            default: start_dev = DEV_FLASH;
        endcase
    end
endmodule

// File: rtl/bdec_boot_fsm.sv
module bdec_boot_fsm
    import boot_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_n,
    input  logic               mem_ok,
    input  logic [NUM_DEV-1:0] win_hit,
    input  dev_e               start_dev,
    output logic               boot_active
);
    boot_st_t st_q, st_d;
    logic     own_hit;

    always_comb begin
        own_hit = mem_ok && win_hit[start_dev];
        st_d         = st_q;
        st_d.as_prev = strobe_n;
        if (!strobe_n) begin
            st_d.hit = st_q.hit | (st_q.boot & own_hit);
        end else begin
            if (!st_q.as_prev && st_q.hit) begin
                st_d.boot = 1'b0;
            end
            st_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BOOT_ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_active = st_q.boot;
endmodule

// File: rtl/bdec_select.sv
module bdec_select
    import boot_dec_pkg::*;
(
    input  logic [NUM_DEV-1:0] win_hit,
    input  logic               low_hit,
    input  logic               boot_active,
    input  logic               strobe_n,
    input  logic               mem_ok,
    input  dev_e               start_dev,
    output logic [NUM_DEV-1:0] cs
);
    logic found;

    always_comb begin
        cs    = '0;
        found = 1'b0;
        if (!strobe_n && mem_ok) begin
            if (boot_active && low_hit) begin
                cs[start_dev] = 1'b1;
            end else begin
                for (int i = 0; i < NUM_DEV; i++) begin
                    if (win_hit[i] && !found) begin
                        cs[i] = 1'b1;
                        found = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bdec_amgen.sv
module bdec_amgen
    import boot_dec_pkg::*;
(
    input  logic       vme_sel,
    input  logic [2:0] fc,
    input  logic [1:0] size,
    output logic [5:0] am,
    output logic       split
);
    always_comb begin
        am = 6'h00;
        if (vme_sel) begin
            unique case (fc[2:1])
                2'b11:   am = AM_SUP_PROG;
                2'b10:   am = AM_SUP_DATA;
                2'b01:   am = AM_USER_PROG;
                default: am = AM_USER_DATA;
            endcase
        end
        split = vme_sel && (size == 2'b00 || size == 2'b11);
    end
endmodule

// File: rtl/boot_redirect_decoder.sv
module boot_redirect_decoder
    import boot_dec_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                BOOT_LG    = 20,
    parameter logic [ADDR_W-1:0] RAM_BASE   = 24'h000000,
    parameter int                RAM_LG     = 22,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 24'h800000,
    parameter int                FLASH_LG   = 21,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 24'hA00000,
    parameter int                ROM_LG     = 20,
    parameter logic [ADDR_W-1:0] VME_BASE   = 24'hC00000,
    parameter int                VME_LG     = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_as_n,
    input  logic [2:0]        cpu_fc,
    input  logic [1:0]        cpu_size,
    input  logic [1:0]        boot_jmp,
    output logic              cs_ram,
    output logic              cs_flash,
    output logic              cs_rom,
    output logic              cs_vme,
    output logic [ADDR_W-1:0] vme_addr,
    output logic [5:0]        vme_am,
    output logic              vme_split
);
    localparam logic [ADDR_W-1:0] WBASE [NUM_DEV] = '{RAM_BASE, FLASH_BASE, ROM_BASE, VME_BASE};
    localparam int                WLG   [NUM_DEV] = '{RAM_LG, FLASH_LG, ROM_LG, VME_LG};

    logic [NUM_DEV-1:0] win_hit;
    logic [NUM_DEV-1:0] cs;
    logic               low_hit;
    logic               mem_ok;
    logic               boot_active;
    dev_e               start_dev;

    // only program and data spaces are memory accesses
    assign mem_ok = cpu_fc[1] ^ cpu_fc[0];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_win
        bdec_window #(
            .AW   (ADDR_W),
            .LG   (WLG[g]),
            .BASE (WBASE[g])
        ) u_win (
            .addr_hi (cpu_addr[ADDR_W-1:WLG[g]]),
            .hit     (win_hit[g])
        );
    end

    bdec_window #(
        .AW   (ADDR_W),
        .LG   (BOOT_LG),
        .BASE ('0)
    ) u_low (
        .addr_hi (cpu_addr[ADDR_W-1:BOOT_LG]),
        .hit     (low_hit)
    );

    bdec_jumper u_jmp (
        .jmp       (boot_jmp),
        .start_dev (start_dev)
    );

    bdec_boot_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_n    (cpu_as_n),
        .mem_ok      (mem_ok),
        .win_hit     (win_hit),
        .start_dev   (start_dev),
        .boot_active (boot_active)
    );

    bdec_select u_sel (
        .win_hit     (win_hit),
        .low_hit     (low_hit),
        .boot_active (boot_active),
        .strobe_n    (cpu_as_n),
        .mem_ok      (mem_ok),
        .start_dev   (start_dev),
        .cs          (cs)
    );

    bdec_amgen u_am (
        .vme_sel (cs[DEV_VME]),
        .fc      (cpu_fc),
        .size    (cpu_size),
        .am      (vme_am),
        .split   (vme_split)
    );

    assign cs_ram   = cs[DEV_RAM];
    assign cs_flash = cs[DEV_FLASH];
    assign cs_rom   = cs[DEV_ROM];
    assign cs_vme   = cs[DEV_VME];
    assign vme_addr = cs[DEV_VME] ? {{(ADDR_W-VME_LG){1'b0}}, cpu_addr[VME_LG-1:0]} : '0;
endmodule

// File: rtl/bdec_checker.sv
module bdec_checker #(
    parameter int AW      = 24,
    parameter int BOOT_LG = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_as_n,
    input logic [2:0]    cpu_fc,
    input logic [1:0]    cpu_size,
    input logic          cs_ram,
    input logic          cs_flash,
    input logic          cs_rom,
    input logic          cs_vme,
    input logic [5:0]    vme_am,
    input logic          vme_split,
    input logic          boot_st
);
    logic [3:0] cs_all;
    logic       in_low;
    assign cs_all = {cs_vme, cs_rom, cs_flash, cs_ram};
    assign in_low = (cpu_addr[AW-1:BOOT_LG] == '0);

    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_all));

    p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_as_n |-> (cs_all == 4'b0000));

    p_no_ram_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_st && in_low) |-> !cs_ram);

    p_am_sup_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_vme && cpu_fc == 3'd6) |-> (vme_am == 6'h3E));

    p_am_sup_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_vme && cpu_fc == 3'd5) |-> (vme_am == 6'h3D));

    p_am_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_vme |-> (vme_am == 6'h00));

    p_exit_at_strobe_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot_st) |-> ($past(cpu_as_n) && !$past(cpu_as_n, 2)));

    p_boot_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_st |=> !boot_st);

    p_split_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_vme && cpu_size == 2'b00) |-> vme_split);
endmodule

bind boot_redirect_decoder bdec_checker #(
    .AW      (ADDR_W),
    .BOOT_LG (BOOT_LG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_as_n  (cpu_as_n),
    .cpu_fc    (cpu_fc),
    .cpu_size  (cpu_size),
    .cs_ram    (cs_ram),
    .cs_flash  (cs_flash),
    .cs_rom    (cs_rom),
    .cs_vme    (cs_vme),
    .vme_am    (vme_am),
    .vme_split (vme_split),
    .boot_st   (boot_active)
);

// File: tb/tb_boot_redirect_decoder.sv
module tb_boot_redirect_decoder;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] C_NONE  = 4'b0000;
    localparam logic [3:0] C_RAM   = 4'b0001;
    localparam logic [3:0] C_FLASH = 4'b0010;
    localparam logic [3:0] C_ROM   = 4'b0100;
    localparam logic [3:0] C_VME   = 4'b1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_as_n = 1'b1;
    logic [2:0]  cpu_fc = 3'd6;
    logic [1:0]  cpu_size = 2'b10;
    logic [1:0]  boot_jmp = 2'b00;
    logic        cs_ram, cs_flash, cs_rom, cs_vme;
    logic [23:0] vme_addr;
    logic [5:0]  vme_am;
    logic        vme_split;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_redirect_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_as_n(cpu_as_n),
        .cpu_fc(cpu_fc), .cpu_size(cpu_size), .boot_jmp(boot_jmp),
        .cs_ram(cs_ram), .cs_flash(cs_flash), .cs_rom(cs_rom), .cs_vme(cs_vme),
        .vme_addr(vme_addr), .vme_am(vme_am), .vme_split(vme_split)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_am(input logic [2:0] fc);
        case (fc)
            3'd6:    return 6'h3E;
            3'd5:    return 6'h3D;
            3'd2:    return 6'h3A;
            default: return 6'h39;
        endcase
    endfunction

    task automatic do_reset(input logic [1:0] jmp);
        @(negedge clk);
        rst_n = 1'b0;
        cpu_as_n = 1'b1;
        boot_jmp = jmp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one full strobe cycle; outputs checked while strobe is low
    task automatic acc(input logic [23:0] a, input logic [2:0] fc, input logic [1:0] sz,
                       input logic [3:0] exp_cs, input string req);
        logic [23:0] ea;
        @(negedge clk);
        cpu_addr = a; cpu_fc = fc; cpu_size = sz; cpu_as_n = 1'b0;
        @(negedge clk);
        chk({28'd0, cs_vme, cs_rom, cs_flash, cs_ram}, {28'd0, exp_cs},
            $sformatf("%s cs @%06h", req, a));
        if (exp_cs == C_VME) begin
            ea = {2'b00, a[21:0]};
            chk({26'd0, vme_am}, {26'd0, exp_am(fc)}, $sformatf("R7 am @%06h fc%0d", a, fc));
            chk({8'd0, vme_addr}, {8'd0, ea}, $sformatf("R8 vme_addr @%06h", a));
            chk({31'd0, vme_split}, {31'd0, (sz == 2'b00 || sz == 2'b11)},
                $sformatf("R9 split sz=%0d", sz));
        end else begin
            chk({26'd0, vme_am}, 32'd0, "R7 am idle");
        end
        @(negedge clk);
        cpu_as_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_idle;
        do_reset(2'b00);
        chk({28'd0, cs_vme, cs_rom, cs_flash, cs_ram}, 32'd0, "R6 idle cs after reset");
        chk({26'd0, vme_am}, 32'd0, "R7 idle am after reset");
    endtask

    task automatic t_flash_boot;
        do_reset(2'b00);
        acc(24'h000000, 3'd6, 2'b00, C_FLASH, "R1 flash first fetch");
        acc(24'h000008, 3'd5, 2'b10, C_FLASH, "R3 low data to flash");
        acc(24'h200000, 3'd5, 2'b10, C_RAM,   "R3 ram above low region");
        acc(24'hA00100, 3'd5, 2'b10, C_ROM,   "R5 rom as plain rom");
        acc(24'h000000, 3'd6, 2'b00, C_FLASH, "R5 still booting");
        acc(24'h800000, 3'd6, 2'b00, C_FLASH, "R4 exit access");
        acc(24'h000000, 3'd6, 2'b00, C_RAM,   "R4 ram after exit");
        acc(24'h800010, 3'd6, 2'b00, C_FLASH, "R10 flash normal window");
        acc(24'h000004, 3'd5, 2'b10, C_RAM,   "R10 boot stays off");
    endtask

    task automatic t_rom_boot;
        do_reset(2'b01);
        acc(24'h000000, 3'd6, 2'b00, C_ROM,   "R2 jmp01 rom");
        acc(24'h800000, 3'd6, 2'b00, C_FLASH, "R5 flash visit");
        acc(24'h000000, 3'd6, 2'b00, C_ROM,   "R5 rom still boot");
        acc(24'hA00000, 3'd6, 2'b00, C_ROM,   "R4 rom exit");
        acc(24'h000000, 3'd6, 2'b00, C_RAM,   "R4 ram after rom exit");
    endtask

    task automatic t_jmp11;
        do_reset(2'b11);
        acc(24'h000000, 3'd6, 2'b00, C_FLASH, "R2 jmp11 flash");
    endtask

    task automatic t_vme_boot;
        do_reset(2'b10);
        acc(24'h000000, 3'd6, 2'b10, C_VME,   "R2 jmp10 vme");
        acc(24'h000004, 3'd5, 2'b00, C_VME,   "R8 vme low data long");
        acc(24'hC00000, 3'd6, 2'b01, C_VME,   "R4 vme exit");
        acc(24'h000000, 3'd6, 2'b00, C_RAM,   "R4 ram after vme exit");
        acc(24'hC01234, 3'd2, 2'b11, C_VME,   "R7 user prog");
        acc(24'hC01236, 3'd1, 2'b10, C_VME,   "R7 user data");
    endtask

    task automatic t_unmapped;
        acc(24'h500000, 3'd5, 2'b10, C_NONE, "R6 unmapped hole");
        acc(24'hB00000, 3'd5, 2'b10, C_NONE, "R6 past rom");
        acc(24'h000000, 3'd7, 2'b10, C_NONE, "R6 fc7");
        acc(24'h000000, 3'd0, 2'b10, C_NONE, "R6 fc0");
        acc(24'h800000, 3'd4, 2'b10, C_NONE, "R6 fc4");
    endtask

    task automatic t_rereset;
        do_reset(2'b10);
        acc(24'h000000, 3'd6, 2'b10, C_VME, "R10 boot after new reset");
    endtask

    initial begin
        t_reset_idle();
        t_flash_boot();
        t_rom_boot();
        t_jmp11();
        t_vme_boot();
        t_unmapped();
        t_rereset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule